// File: doc/BRIEF.md
# Receive Frame Ring Manager

This block stores incoming Ethernet frames in a circular region of a byte-wide packet memory. Bytes arrive from the MAC side as a valid/ready stream. The last beat of a frame carries a 16-bit status word and an accept bit from the address filter. The block places each accepted frame behind a six-byte header and counts the frames it stores. A frame that would run into space the host has not yet released is dropped, and a sticky overflow flag records the drop.

The host programs the ring bounds and the release pointer through byte-wide register writes. It walks the stored frames through a read port whose pointer can advance by itself. To release a frame, the host moves the release pointer to one byte before that frame's successor, then issues a decrement on the frame counter. Pointers are `ADDR_W` bits wide, with 9 ≤ `ADDR_W` ≤ 16. Each one is built from a low byte and the low `ADDR_W-8` bits of a high byte.

Top module: `rxr_ring_mgr`

## Requirements
- R1: The ring is every address from ring start to ring end, both included. Frame writes and auto-advancing host reads that pass ring end continue at ring start.
- R2: Register select codes are 0/1 for the ring start low/high byte, 2/3 for ring end, 4/5 for the release pointer, and 6/7 for the read pointer. A write to either ring start byte loads the hardware write pointer (`wr_ptr`) with the new ring start value in the same cycle.
- R3: A stored frame begins at `wr_ptr` with a six-byte header, followed by its data bytes in arrival order. The header holds the successor address (low byte, then high byte), then the data byte count (low, high), then the status word (low, high).
- R4: A write to the release pointer low byte (code 4) changes nothing by itself. The release pointer takes the combined value only when the high byte (code 5) is written.
- R5: `pkt_cnt` rises by one for each stored frame and stops at 255. `pkt_dec` lowers it by one and has no effect at zero. A store and a decrement in the same cycle leave it unchanged.
- R6: The successor address is the frame base plus 6 plus the byte count, rounded up to even, wrapped into the ring. An odd-length frame therefore also needs room for its pad byte.
- R7: With `wr_ptr` at ring start and the release pointer at ring end, all ring bytes except ring end can hold a frame. Ring end is the value the host programs when the successor address equals ring start.
- R8: `rd_data` shows the byte at `rd_ptr` one cycle after `rd_req`, and `rd_valid` is high in that cycle. While `auto_inc` is high, each request advances `rd_ptr` by one, wrapping as in R1. While `auto_inc` is low, `rd_ptr` stays put.
- R9: A frame that needs a byte at or beyond the release pointer position (counted from `wr_ptr`) is dropped. In that case `wr_ptr` and `pkt_cnt` are unchanged and `ovf_flag` is set. `ovf_flag` stays set until `ovf_clr`.
- R10: A frame whose first byte arrives while `rx_en` is low is consumed but not stored. A frame already under way when `rx_en` falls is stored in full.
- R11: A frame whose last beat has `s_accept` low is not stored and does not change `wr_ptr`, `pkt_cnt` or `ovf_flag`.
- R12: After the last beat of a stored frame, `s_ready` is low for exactly six cycles while the header is written. `wr_ptr` and `pkt_cnt` update as `s_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Reception enable, sampled on the first byte of a frame |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_accept | input | 1 | Filter verdict, sampled with s_last |
| s_status | input | 16 | Frame status, sampled with s_last |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select (codes in R2) |
| reg_wdata | input | 8 | Host register write byte |
| auto_inc | input | 1 | Read pointer auto-advance enable |
| rd_req | input | 1 | Host buffer read request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data byte |
| rd_ptr | output | ADDR_W | Host read pointer |
| wr_ptr | output | ADDR_W | Hardware write pointer (next frame base) |
| pkt_dec | input | 1 | Frame counter decrement |
| pkt_cnt | output | 8 | Stored frame count |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky frame-drop-on-overflow flag |

## Verification
The hardest condition to reach is a frame that exactly fills the free space, or misses it by a single pad byte, at the moment the ring is wrapping or the write pointer is back at ring start. The stimulus sets these up on purpose. The ring start is reprogrammed to snap the write pointer home. The release pointer is set one or two bytes short of a frame's need. A long run of eight-byte frames cycles through the ring, with the release pointer moved after each frame by the host rule, including the ring-end substitution. The same run drives the counter into saturation. Stored bytes are read back through the wrapping read pointer and compared against a queue of expected header and data bytes.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive ring manager.
package rxr_pkg;
    localparam int HDR_LEN = 6;   // header bytes ahead of each frame
    localparam int LEN_W   = 16;  // width of header byte count and status

    typedef enum logic [2:0] {
        SEL_START_LO = 3'd0,
        SEL_START_HI = 3'd1,
        SEL_END_LO   = 3'd2,
        SEL_END_HI   = 3'd3,
        SEL_FREE_LO  = 3'd4,
        SEL_FREE_HI  = 3'd5,
        SEL_RDP_LO   = 3'd6,
        SEL_RDP_HI   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_RECV,
        WS_DROP,
        WS_HDR
    } wr_state_e;
endpackage

// File: rtl/rxr_byte_mem.sv
// Byte-wide packet memory: one write port and one registered read port.
// Assumes the caller keeps addresses inside the array.
module rxr_byte_mem #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxr_host_regs.sv
// Host-visible pointers: ring start/end, release pointer with a staged
// low byte, and the auto-advancing read pointer.
// Assumes 9 <= ADDR_W <= 16 and that all pointers lie within the ring.
module rxr_host_regs
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              rd_req,
    input  logic              auto_inc,
    output logic [ADDR_W-1:0] ring_start,
    output logic [ADDR_W-1:0] ring_end,
    output logic [ADDR_W-1:0] free_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              start_load,
    output logic [ADDR_W-1:0] start_next
);
    localparam int HI_W = ADDR_W - 8;

    logic [7:0] free_lo_q;

    function automatic logic [ADDR_W-1:0] put_lo(input logic [ADDR_W-1:0] p, input logic [7:0] b);
        return {p[ADDR_W-1:8], b};
    endfunction

    function automatic logic [ADDR_W-1:0] put_hi(input logic [ADDR_W-1:0] p, input logic [7:0] b);
        return {b[HI_W-1:0], p[7:0]};
    endfunction

    // Next ring start value, shared with the frame writer.
    always_comb begin
        start_load = reg_we && (reg_sel == SEL_START_LO || reg_sel == SEL_START_HI);
        start_next = (reg_sel == SEL_START_LO) ? put_lo(ring_start, reg_wdata)
                                               : put_hi(ring_start, reg_wdata);
    end

    // Ring bounds and release pointer (commit on high byte).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_start <= '0;
            ring_end   <= '1;
            free_ptr   <= '1;
            free_lo_q  <= '0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_START_LO, SEL_START_HI: ring_start <= start_next;
                SEL_END_LO:  ring_end  <= put_lo(ring_end, reg_wdata);
                SEL_END_HI:  ring_end  <= put_hi(ring_end, reg_wdata);
                SEL_FREE_LO: free_lo_q <= reg_wdata;
                SEL_FREE_HI: free_ptr  <= put_hi({{HI_W{1'b0}}, free_lo_q}, reg_wdata);
                default: ;
            endcase
        end
    end

    // Read pointer: host write wins, else wrapping auto-advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (reg_we && reg_sel == SEL_RDP_LO) begin
            rd_ptr <= put_lo(rd_ptr, reg_wdata);
        end else if (reg_we && reg_sel == SEL_RDP_HI) begin
            rd_ptr <= put_hi(rd_ptr, reg_wdata);
        end else if (rd_req && auto_inc) begin
            rd_ptr <= (rd_ptr == ring_end) ? ring_start : rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_pkt_counter.sv
// Stored-frame counter: saturating increment, floor-limited decrement.
module rxr_pkt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Net change of one step in either direction, none when both.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (inc && !dec && cnt != CNT_MAX) cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0)      cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rxr_frame_writer.sv
// Frame writer: places stream bytes behind a reserved header area, checks
// each byte against the space up to the release pointer, then writes the
// six header bytes and advances the write pointer.
// Assumes ring start <= ring end and frames shorter than 65536 bytes.
module rxr_frame_writer
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_accept,
    input  logic [15:0]       s_status,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [ADDR_W-1:0] ring_end,
    input  logic [ADDR_W-1:0] free_ptr,
    input  logic              start_load,
    input  logic [ADDR_W-1:0] start_next,
    input  logic              ovf_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              frame_done,
    output logic              ovf_flag
);
    localparam int KW = LEN_W + 1;   // relative-offset width
    localparam int OW = ADDR_W + 1;  // ring-offset width

    wr_state_e         st_q;
    logic [OW-1:0]     base_q, fd_q;
    logic [LEN_W-1:0]  len_q;
    logic              bad_q;
    logic [ADDR_W-1:0] next_q;
    logic [15:0]       status_q;
    logic [2:0]        hcnt_q;

    logic [OW-1:0]     ring_n, wr_off, free_off, fd_now;
    logic [OW-1:0]     eff_fd, eff_base;
    logic [LEN_W-1:0]  eff_len, new_len;
    logic              eff_bad, new_bad, fits, pad_bad;
    logic [KW-1:0]     k_cur, k_end;
    logic              beat, take, commit, ovf_set;
    logic [15:0]       next16;

    function automatic logic [ADDR_W-1:0] rel_addr(input logic [OW-1:0] base, input logic [KW-1:0] k,
                                                   input logic [OW-1:0] n, input logic [ADDR_W-1:0] st);
        logic [KW:0] s;
        s = (KW+1)'(base) + (KW+1)'(k);
        if (s >= (KW+1)'(n)) s = s - (KW+1)'(n);
        return st + s[ADDR_W-1:0];
    endfunction

    // Ring size, offsets and free distance from the write pointer.
    always_comb begin
        ring_n   = {1'b0, ring_end} - {1'b0, ring_start} + 1'b1;
        wr_off   = {1'b0, wr_ptr - ring_start};
        free_off = {1'b0, free_ptr - ring_start};
        fd_now   = (free_off >= wr_off) ? free_off - wr_off : free_off + ring_n - wr_off;
    end

    // Per-beat decisions: room check, pad check, commit and overflow.
    always_comb begin
        s_ready  = (st_q != WS_HDR);
        beat     = s_valid && s_ready;
        take     = beat && ((st_q == WS_IDLE && rx_en) || st_q == WS_RECV);
        eff_fd   = (st_q == WS_IDLE) ? fd_now : fd_q;
        eff_base = (st_q == WS_IDLE) ? wr_off : base_q;
        eff_len  = (st_q == WS_IDLE) ? '0 : len_q;
        eff_bad  = (st_q == WS_IDLE) ? 1'b0 : bad_q;
        k_cur    = KW'(eff_len) + KW'(HDR_LEN);
        fits     = k_cur < KW'(eff_fd);
        new_len  = eff_len + 1'b1;
        new_bad  = eff_bad || !fits;
        pad_bad  = new_len[0] && (KW'(new_len) + KW'(HDR_LEN) >= KW'(eff_fd));
        k_end    = KW'(new_len) + KW'(HDR_LEN) + KW'(new_len[0]);
        commit   = take && s_last && s_accept && !new_bad && !pad_bad;
        ovf_set  = take && ((!eff_bad && !fits) || (s_last && s_accept && !new_bad && pad_bad));
        frame_done = (st_q == WS_HDR) && (hcnt_q == 3'd5);
        next16   = 16'(next_q);
    end

    // Memory write port: header bytes in WS_HDR, data bytes otherwise.
    always_comb begin
        if (st_q == WS_HDR) begin
            mem_we    = 1'b1;
            mem_waddr = rel_addr(base_q, KW'(hcnt_q), ring_n, ring_start);
            case (hcnt_q)
                3'd0:    mem_wdata = next16[7:0];
                3'd1:    mem_wdata = next16[15:8];
                3'd2:    mem_wdata = len_q[7:0];
                3'd3:    mem_wdata = len_q[15:8];
                3'd4:    mem_wdata = status_q[7:0];
                default: mem_wdata = status_q[15:8];
            endcase
        end else begin
            mem_we    = take && !eff_bad && fits;
            mem_waddr = rel_addr(eff_base, k_cur, ring_n, ring_start);
            mem_wdata = s_data;
        end
    end

    // Frame state sequencing and frame context capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WS_IDLE;
            base_q   <= '0;
            fd_q     <= '0;
            len_q    <= '0;
            bad_q    <= 1'b0;
            next_q   <= '0;
            status_q <= '0;
            hcnt_q   <= '0;
        end else begin
            case (st_q)
                WS_IDLE: if (beat) begin
                    if (rx_en) st_q <= s_last ? (commit ? WS_HDR : WS_IDLE) : WS_RECV;
                    else if (!s_last) st_q <= WS_DROP;
                end
                WS_RECV: if (beat && s_last) st_q <= commit ? WS_HDR : WS_IDLE;
                WS_DROP: if (beat && s_last) st_q <= WS_IDLE;
                default: if (hcnt_q == 3'd5) st_q <= WS_IDLE;
            endcase
            if (take) begin
                len_q  <= new_len;
                bad_q  <= new_bad;
                fd_q   <= eff_fd;
                base_q <= eff_base;
            end
            if (commit) begin
                next_q   <= rel_addr(eff_base, k_end, ring_n, ring_start);
                status_q <= s_status;
                hcnt_q   <= '0;
            end else if (st_q == WS_HDR) begin
                hcnt_q   <= hcnt_q + 1'b1;
            end
        end
    end

    // Write pointer: ring start programming wins over frame commit.
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_ptr <= '0;
        else if (start_load) wr_ptr <= start_next;
        else if (frame_done) wr_ptr <= next_q;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/rxr_ring_mgr.sv
// Receive ring manager top: joins host pointers, frame writer, frame
// counter and packet memory. Assumes 9 <= ADDR_W <= 16.
module rxr_ring_mgr #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    input  logic              s_accept,
    input  logic [15:0]       s_status,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              auto_inc,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr,
    input  logic              pkt_dec,
    output logic [CNT_W-1:0]  pkt_cnt,
    input  logic              ovf_clr,
    output logic              ovf_flag
);
    logic [ADDR_W-1:0] ring_start, ring_end, free_ptr, start_next;
    logic              start_load, mem_we, frame_done;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;

    rxr_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_req(rd_req), .auto_inc(auto_inc),
        .ring_start(ring_start), .ring_end(ring_end), .free_ptr(free_ptr),
        .rd_ptr(rd_ptr), .start_load(start_load), .start_next(start_next)
    );

    rxr_frame_writer #(.ADDR_W(ADDR_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .s_accept(s_accept), .s_status(s_status), .ring_start(ring_start),
        .ring_end(ring_end), .free_ptr(free_ptr), .start_load(start_load),
        .start_next(start_next), .ovf_clr(ovf_clr), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wr_ptr(wr_ptr),
        .frame_done(frame_done), .ovf_flag(ovf_flag)
    );

    rxr_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(frame_done), .dec(pkt_dec), .cnt(pkt_cnt)
    );

    rxr_byte_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .re(rd_req), .raddr(rd_ptr), .rdata(rd_data)
    );

    // Read data valid follows a request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_req;
    end
endmodule

// File: rtl/rxr_ring_mgr_chk.sv
// Protocol checker for the receive ring manager, bound to the top.
module rxr_ring_mgr_chk #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic [7:0]        reg_wdata,
    input logic              rd_req,
    input logic              auto_inc,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] ring_start,
    input logic [ADDR_W-1:0] ring_end,
    input logic              s_ready,
    input logic              pkt_dec,
    input logic [CNT_W-1:0]  pkt_cnt,
    input logic              ovf_clr,
    input logic              ovf_flag
);
    p_start_loads_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == 3'd0) |=> (wr_ptr[7:0] == $past(reg_wdata)));

    p_rd_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && auto_inc && !reg_we && rd_ptr == ring_end) |=> (rd_ptr == ring_start));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !auto_inc && !reg_we) |=> $stable(rd_ptr));

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pkt_cnt) |-> ((pkt_cnt == $past(pkt_cnt) + 1'b1) || (pkt_cnt == $past(pkt_cnt) - 1'b1)));

    p_cnt_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == '0 && pkt_dec) |=> (pkt_cnt != '1));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_hdr_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_ready) |=> !s_ready);
endmodule

bind rxr_ring_mgr rxr_ring_mgr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_req(rd_req), .auto_inc(auto_inc),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .ring_start(ring_start),
    .ring_end(ring_end), .s_ready(s_ready), .pkt_dec(pkt_dec),
    .pkt_cnt(pkt_cnt), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
);

// File: tb/rxr_ring_mgr_tb.sv
module rxr_ring_mgr_tb;
    localparam int CLK_P = 10;
    localparam int AW    = 9;
    localparam int RS    = 'h10;
    localparam int RE    = 'hFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_en = 1'b0, s_valid = 1'b0, s_last = 1'b0, s_accept = 1'b0;
    logic [7:0] s_data = '0, reg_wdata = '0;
    logic [15:0] s_status = '0;
    logic reg_we = 1'b0, auto_inc = 1'b0, rd_req = 1'b0, pkt_dec = 1'b0, ovf_clr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic s_ready, rd_valid, ovf_flag;
    logic [7:0] rd_data, pkt_cnt;
    logic [AW-1:0] rd_ptr, wr_ptr;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];

    rxr_ring_mgr #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .s_accept(s_accept), .s_status(s_status),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .auto_inc(auto_inc),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ptr(rd_ptr),
        .wr_ptr(wr_ptr), .pkt_dec(pkt_dec), .pkt_cnt(pkt_cnt), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int wrap(input int x);
        return (x > RE) ? x - (RE - RS + 1) : x;
    endfunction

    function automatic int succ(input int base, input int len);
        return wrap(base + 6 + len + (len % 2));
    endfunction

    task automatic wreg(input int sel, input int val);
        reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = 8'(val);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_ptr(input int lo_sel, input int val);
        wreg(lo_sel, val & 'hFF);
        wreg(lo_sel + 1, (val >> 8) & 'hFF);
    endtask

    task automatic pulse_dec();
        pkt_dec = 1'b1; @(negedge clk); pkt_dec = 1'b0;
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    endtask

    // Driver: streams one frame; returns cycles of stall after its last beat.
    task automatic send_frame(input int len, input int status, input bit acc,
                              input int seed, input int en_off_at, output int stall);
        for (int i = 0; i < len; i++) begin
            s_valid = 1'b1; s_data = 8'(seed + i); s_last = (i == len - 1);
            s_accept = acc; s_status = 16'(status);
            if (i == en_off_at) rx_en = 1'b0;
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
        stall = 0;
        while (!s_ready) begin stall++; @(negedge clk); end
    endtask

    // Scoreboard producer: expected header and data of a stored frame.
    task automatic expect_frame(input int len, input int status, input int seed, input int nxt);
        exp_q.push_back(8'(nxt)); exp_q.push_back(8'(nxt >> 8));
        exp_q.push_back(8'(len)); exp_q.push_back(8'(len >> 8));
        exp_q.push_back(8'(status)); exp_q.push_back(8'(status >> 8));
        for (int i = 0; i < len; i++) exp_q.push_back(8'(seed + i));
    endtask

    task automatic host_read(input int addr, input int n);
        set_ptr(6, addr);
        rd_req = 1'b1;
        repeat (n) @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_eq("R3 scoreboard drained", exp_q.size(), 0);
    endtask

    // Monitor: compares every read byte against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8 unexpected read actual=0x%0h expected=none", rd_data);
            end else begin
                chk_eq("R3/R8 read byte", rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int st, ew;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("reset pkt_cnt", pkt_cnt, 0);
        chk_eq("reset ovf_flag", ovf_flag, 0);
        chk_eq("reset wr_ptr", wr_ptr, 0);
        chk_eq("reset s_ready", s_ready, 1);
        chk_eq("reset rd_valid", rd_valid, 0);

        wreg(0, RS);
        chk_eq("R2 start loads wr_ptr", wr_ptr, RS);
        wreg(1, 0);
        set_ptr(2, RE);
        set_ptr(4, RE);
        rx_en = 1'b1; auto_inc = 1'b1;

        send_frame(5, 'h1234, 1'b1, 'h40, -1, st);
        chk_eq("R12 header stall cycles", st, 6);
        chk_eq("R6 odd frame successor", wr_ptr, 'h1C);
        chk_eq("R5 count after store", pkt_cnt, 1);
        send_frame(8, 'hBEEF, 1'b1, 'h80, -1, st);
        chk_eq("R6 even frame successor", wr_ptr, 'h2A);
        chk_eq("R5 count second store", pkt_cnt, 2);

        expect_frame(5, 'h1234, 'h40, 'h1C);
        host_read('h10, 11);
        expect_frame(8, 'hBEEF, 'h80, 'h2A);
        host_read('h1C, 14);

        auto_inc = 1'b0;
        repeat (3) exp_q.push_back(8'd5);
        host_read('h12, 3);
        chk_eq("R8 pointer holds without auto_inc", rd_ptr, 'h12);
        auto_inc = 1'b1;

        send_frame(4, 'h0, 1'b0, 'h55, -1, st);
        chk_eq("R11 reject keeps wr_ptr", wr_ptr, 'h2A);
        chk_eq("R11 reject keeps count", pkt_cnt, 2);
        chk_eq("R11 reject no overflow", ovf_flag, 0);

        rx_en = 1'b0;
        send_frame(3, 'h0, 1'b1, 'h66, -1, st);
        chk_eq("R10 disabled frame not stored", wr_ptr, 'h2A);
        rx_en = 1'b1;
        send_frame(4, 'h0A0B, 1'b1, 'hC0, 1, st);
        chk_eq("R10 in-progress frame stored", wr_ptr, 'h34);
        chk_eq("R10 in-progress count", pkt_cnt, 3);
        rx_en = 1'b1;
        expect_frame(4, 'h0A0B, 'hC0, 'h34);
        host_read('h2A, 10);

        pulse_dec(); pulse_dec();
        chk_eq("R5 decrement", pkt_cnt, 1);
        pulse_dec(); pulse_dec();
        chk_eq("R5 decrement at zero", pkt_cnt, 0);

        wreg(4, 'h3F);
        send_frame(6, 'h0001, 1'b1, 'h10, -1, st);
        chk_eq("R4 low byte alone not applied", wr_ptr, 'h40);
        chk_eq("R4 no overflow", ovf_flag, 0);
        wreg(5, 0);
        set_ptr(4, 'h47);
        send_frame(2, 'h0, 1'b1, 'h20, -1, st);
        chk_eq("R9 overflow flag", ovf_flag, 1);
        chk_eq("R9 wr_ptr restored", wr_ptr, 'h40);
        chk_eq("R9 count unchanged", pkt_cnt, 1);
        pulse_clr();
        chk_eq("R9 flag cleared", ovf_flag, 0);
        send_frame(1, 'h0, 1'b1, 'h30, -1, st);
        chk_eq("R6 pad byte overflow", ovf_flag, 1);
        chk_eq("R6 pad overflow wr_ptr", wr_ptr, 'h40);
        pulse_clr();

        set_ptr(4, 'h3F);
        send_frame(200, 'h7788, 1'b1, 'h01, -1, st);
        chk_eq("R1 wrapped successor", wr_ptr, 'h1E);
        chk_eq("R1 wrapped count", pkt_cnt, 2);
        expect_frame(200, 'h7788, 'h01, 'h1E);
        host_read('h40, 206);
        chk_eq("R1 read pointer wrapped", rd_ptr, 'h1E);

        set_ptr(0, RS);
        chk_eq("R2 reprogram start", wr_ptr, RS);
        set_ptr(4, RE);
        send_frame(233, 'h0, 1'b1, 'h00, -1, st);
        chk_eq("R7 one pad byte too many", ovf_flag, 1);
        chk_eq("R7 wr_ptr kept", wr_ptr, RS);
        pulse_clr();
        send_frame(232, 'h0, 1'b1, 'h00, -1, st);
        chk_eq("R7 full ring frame stored", wr_ptr, 'hFE);
        chk_eq("R7 no overflow", ovf_flag, 0);

        set_ptr(0, RS);
        ew = RS;
        for (int f = 0; f < 256; f++) begin
            set_ptr(4, (ew == RS) ? RE : ew - 1);
            send_frame(2, f, 1'b1, f, -1, st);
            ew = succ(ew, 2);
            chk_eq("R7 release-rule frame run wr_ptr", wr_ptr, ew);
        end
        chk_eq("R7 no overflow in run", ovf_flag, 0);
        chk_eq("R5 saturated count", pkt_cnt, 255);
        pulse_dec();
        chk_eq("R5 decrement from saturation", pkt_cnt, 254);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule